// File: doc/BRIEF.md
# Asynchronous Start/Stop Serial Transmitter with Line Break

This block turns parallel characters into one serial transmit line in start/stop framing. Each frame has a low start bit and then 5 to 8 data bits, least significant first. An optional parity bit comes next, with even or odd sense. The frame ends with a high stop period of one, one and a half or two bit times. All timing comes from a clock enable at sixteen times the bit rate. One bit lasts 16 enabled ticks, so a stop period of one and a half bits is 24 ticks.

The producer offers a character with a valid/ready handshake. Ready is high only while no frame is being sent. Length, parity and stop settings are captured on the cycle a character is accepted, so changing them later cannot disturb a frame already on the line.

A separate break request overrides framing and drives the line low for as long as it is held. Any frame in progress is dropped. After the request is released, the line is held high for one full bit time before a new character can be taken. A busy output shows whether the transmitter is doing anything other than idling.

Top module: `serial_tx_frame`

## Requirements
- R1: After reset, and whenever no frame or break is active, txLine is high, busy is low and inReady is high.
- R2: A character is accepted on a clock edge where inValid and inReady are both high. From the next cycle until the frame's last stop tick, busy is high and inReady is low.
- R3: A frame starts with txLine low for 16 enabled ticks. The low level appears in the cycle after acceptance. The data bits follow least significant bit first, each lasting 16 ticks.
- R4: cfgLen selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. Bits of inData above the selected length are never sent.
- R5: When cfgParEn is 1, one parity bit follows the data. With cfgParOdd=0 the total count of ones in the sent data bits plus the parity bit is even. With cfgParOdd=1 that total is odd.
- R6: The stop period is high and lasts 16 ticks for cfgStop=0, 24 ticks for cfgStop=1, and 32 ticks for cfgStop=2 or 3.
- R7: inData, cfgLen, cfgParEn, cfgParOdd and cfgStop are sampled only at acceptance. Changing them during a frame does not alter it.
- R8: Frame timing advances only in cycles where tickEn is 1. With tickEn held at 0, txLine does not change except through a break.
- R9: While breakReq is high, txLine is low from the cycle after breakReq is first seen, and inReady is low. A frame in progress is abandoned and does not resume.
- R10: After breakReq falls, txLine is high and busy stays high for 16 ticks. The block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Enable at sixteen times the bit rate |
| inData | input | DATA_W | Character to send |
| cfgLen | input | LEN_W | Data length code (0..3 for 5..8 bits) |
| cfgParEn | input | 1 | Append a parity bit |
| cfgParOdd | input | 1 | Parity sense: 0 even, 1 odd |
| cfgStop | input | STOP_W | Stop length code: 0 one bit, 1 one and a half, 2/3 two |
| inValid | input | 1 | Character offered |
| inReady | output | 1 | Character can be accepted this cycle |
| breakReq | input | 1 | Hold the line low (break) |
| txLine | output | 1 | Serial transmit line, idles high |
| busy | output | 1 | Frame, break or recovery in progress |

## Verification
Wrong internal state in this transmitter shows up as the wrong line level, usually within one bit time. A shift or bit-count error puts a wrong data or parity level into a 16-tick window. An error in the tick limit moves every later edge, and the stop period ends early or late by a whole or half bit. Each expected frame is compared level by level over every cycle of every segment, so a one-cycle shift is caught at the boundary where it happens. Break faults show at once: the line must be low one cycle after the request, and the recovery window must measure exactly 16 ticks before ready comes back.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  // Strobes from the sequencing control to the shift datapath
  typedef struct packed {
    logic load;       // capture character and configuration
    logic clrTick;    // restart the bit-time tick counter
    logic shift;      // advance to the next data bit
    logic stopPhase;  // apply the stop-period tick limit
    logic lineLow;    // drive the line low (start bit or break)
    logic lineData;   // drive the current data bit
    logic linePar;    // drive the latched parity bit
  } txStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK,
    ST_RECOV
  } txState_t;

endpackage

// File: rtl/serial_tx_datapath.sv
module serial_tx_datapath
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int LEN_W  = 2,
  parameter int STOP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] inData,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic [STOP_W-1:0] cfgStop,
  input  txStrobe_t         strobe,
  output logic              bitDone,
  output logic              lastBit,
  output logic              parEnLatched,
  output logic              txLine
);

  localparam int HALF    = OVS / 2;
  localparam int TICK_W  = $clog2(2 * OVS);
  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;

  logic [DATA_W-1:0] shReg;
  logic [CNT_W-1:0]  bitsLeft;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] lastTick;
  logic [STOP_W-1:0] stopL;
  logic              parBitL;
  logic              parEnL;

  logic [CNT_W-1:0]  lenBits;
  logic [DATA_W-1:0] charMask;
  logic              parNext;

  assign lenBits = CNT_W'(MIN_LEN) + CNT_W'(cfgLen);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign charMask[i] = (CNT_W'(i) < lenBits);
  end

  assign parNext = (^(inData & charMask)) ^ cfgParOdd;

  // Tick limit for the current bit slot; only the stop slot may differ
  always_comb begin
    lastTick = TICK_W'(OVS - 1);
    if (strobe.stopPhase) begin
      case (stopL)
        STOP_W'(0): lastTick = TICK_W'(OVS - 1);
        STOP_W'(1): lastTick = TICK_W'(OVS + HALF - 1);
        default:    lastTick = TICK_W'(2 * OVS - 1);
      endcase
    end
  end

  assign bitDone = tickEn && (tickCnt == lastTick);
  assign lastBit = (bitsLeft == CNT_W'(1));
  assign parEnLatched = parEnL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.clrTick) begin
      tickCnt <= '0;
    end else if (tickEn) begin
      tickCnt <= tickCnt + TICK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitsLeft <= '0;
      parBitL  <= 1'b0;
      parEnL   <= 1'b0;
      stopL    <= '0;
    end else if (strobe.load) begin
      shReg    <= inData & charMask;
      bitsLeft <= lenBits;
      parBitL  <= parNext;
      parEnL   <= cfgParEn;
      stopL    <= cfgStop;
    end else if (strobe.shift) begin
      shReg    <= shReg >> 1;
      bitsLeft <= bitsLeft - CNT_W'(1);
    end
  end

  always_comb begin
    if (strobe.lineLow)       txLine = 1'b0;
    else if (strobe.lineData) txLine = shReg[0];
    else if (strobe.linePar)  txLine = parBitL;
    else                      txLine = 1'b1;
  end

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       breakReq,
  input  logic       bitDone,
  input  logic       lastBit,
  input  logic       parEnLatched,
  output txStrobe_t  strobe,
  output logic       inReady,
  output logic       busy
);

  txState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    strobe = '0;
    nxt    = state;
    case (state)
      ST_IDLE: begin
        if (breakReq) begin
          nxt = ST_BRK;
          strobe.clrTick = 1'b1;
        end else if (inValid) begin
          nxt = ST_START;
          strobe.load    = 1'b1;
          strobe.clrTick = 1'b1;
        end
      end
      ST_START: begin
        strobe.lineLow = 1'b1;
        if (bitDone) begin
          nxt = ST_DATA;
          strobe.clrTick = 1'b1;
        end
      end
      ST_DATA: begin
        strobe.lineData = 1'b1;
        if (bitDone) begin
          strobe.clrTick = 1'b1;
          if (lastBit) nxt = parEnLatched ? ST_PAR : ST_STOP;
          else         strobe.shift = 1'b1;
        end
      end
      ST_PAR: begin
        strobe.linePar = 1'b1;
        if (bitDone) begin
          nxt = ST_STOP;
          strobe.clrTick = 1'b1;
        end
      end
      ST_STOP: begin
        strobe.stopPhase = 1'b1;
        if (bitDone) begin
          nxt = ST_IDLE;
          strobe.clrTick = 1'b1;
        end
      end
      ST_BRK: begin
        strobe.lineLow = 1'b1;
        if (!breakReq) begin
          nxt = ST_RECOV;
          strobe.clrTick = 1'b1;
        end
      end
      ST_RECOV: begin
        if (bitDone) begin
          nxt = ST_IDLE;
          strobe.clrTick = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase

    // Break overrides any frame or recovery in progress
    if (breakReq && state != ST_IDLE && state != ST_BRK) begin
      nxt            = ST_BRK;
      strobe.clrTick = 1'b1;
      strobe.load    = 1'b0;
      strobe.shift   = 1'b0;
    end
  end

  assign inReady = (state == ST_IDLE) && !breakReq;
  assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/serial_tx_frame.sv
module serial_tx_frame
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int LEN_W  = 2,
  parameter int STOP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [DATA_W-1:0] inData,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic [STOP_W-1:0] cfgStop,
  input  logic              inValid,
  output logic              inReady,
  input  logic              breakReq,
  output logic              txLine,
  output logic              busy
);

  txStrobe_t strobe;
  logic      bitDone;
  logic      lastBit;
  logic      parEnLatched;

  serial_tx_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .breakReq     (breakReq),
    .bitDone      (bitDone),
    .lastBit      (lastBit),
    .parEnLatched (parEnLatched),
    .strobe       (strobe),
    .inReady      (inReady),
    .busy         (busy)
  );

  serial_tx_datapath #(
    .DATA_W (DATA_W),
    .OVS    (OVS),
    .LEN_W  (LEN_W),
    .STOP_W (STOP_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .tickEn       (tickEn),
    .inData       (inData),
    .cfgLen       (cfgLen),
    .cfgParEn     (cfgParEn),
    .cfgParOdd    (cfgParOdd),
    .cfgStop      (cfgStop),
    .strobe       (strobe),
    .bitDone      (bitDone),
    .lastBit      (lastBit),
    .parEnLatched (parEnLatched),
    .txLine       (txLine)
  );

endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic inValid,
  input logic inReady,
  input logic breakReq,
  input logic txLine,
  input logic busy
);

  p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  p_ready_only_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !busy);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (busy && !inReady));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !txLine);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tickEn && !breakReq && !$past(breakReq)) |=> $stable(txLine));

  p_break_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (breakReq && $past(breakReq)) |-> !txLine);

  p_break_not_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> !inReady);

  p_release_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakReq) |=> (txLine && busy));

endmodule

bind serial_tx_frame serial_tx_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .inValid  (inValid),
  .inReady  (inReady),
  .breakReq (breakReq),
  .txLine   (txLine),
  .busy     (busy)
);

// File: tb/serial_tx_frame_tb.sv
module serial_tx_frame_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic  lvl;
    int    dur;
    string tag;
    bit    last;
  } seg_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic [7:0] inData = '0;
  logic [1:0] cfgLen = '0;
  logic       cfgParEn = 1'b0;
  logic       cfgParOdd = 1'b0;
  logic [1:0] cfgStop = '0;
  logic       inValid = 1'b0;
  logic       breakReq = 1'b0;
  logic       inReady;
  logic       txLine;
  logic       busy;

  int   total = 0;
  int   bad = 0;
  seg_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_tx_frame u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .inData    (inData),
    .cfgLen    (cfgLen),
    .cfgParEn  (cfgParEn),
    .cfgParOdd (cfgParOdd),
    .cfgStop   (cfgStop),
    .inValid   (inValid),
    .inReady   (inReady),
    .breakReq  (breakReq),
    .txLine    (txLine),
    .busy      (busy)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: pushes the expected line segments, then performs the handshake
  task automatic sendFrame(input logic [7:0] data, input logic [1:0] lenC,
                           input logic pe, input logic po,
                           input logic [1:0] sc, input bit push);
    int         n;
    logic [7:0] mask;
    logic       p;
    seg_t       s;
    n    = 5 + int'(lenC);
    mask = 8'hFF >> (3 - int'(lenC));
    p    = (^(data & mask)) ^ po;
    if (push) begin
      s = '{1'b0, 16, "R3 start", 1'b0};
      expQ.push_back(s);
      for (int i = 0; i < n; i++) begin
        s = '{data[i], 16, "R4 data", 1'b0};
        expQ.push_back(s);
      end
      if (pe) begin
        s = '{p, 16, "R5 parity", 1'b0};
        expQ.push_back(s);
      end
      s = '{1'b1, (sc == 2'd0) ? 16 : (sc == 2'd1) ? 24 : 32, "R6 stop", 1'b1};
      expQ.push_back(s);
    end
    @(negedge clk);
    inData    = data;
    cfgLen    = lenC;
    cfgParEn  = pe;
    cfgParOdd = po;
    cfgStop   = sc;
    inValid   = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(!inReady && busy, "R2 accept", {inReady, busy}, 2'b01);
    // R7: scramble every setting while the frame is on the line
    inData    = ~data;
    cfgLen    = ~lenC;
    cfgParEn  = ~pe;
    cfgParOdd = ~po;
    cfgStop   = ~sc;
  endtask

  task automatic waitDrain();
    while (expQ.size() > 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: on a start edge, compares every cycle of each expected segment
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && expQ.size() > 0 && txLine === 1'b0) begin
        bit fin;
        fin = 1'b0;
        while (!fin) begin
          seg_t s;
          int   errCnt;
          logic seen;
          s      = expQ.pop_front();
          errCnt = 0;
          seen   = s.lvl;
          for (int k = 0; k < s.dur; k++) begin
            if (txLine !== s.lvl) begin
              errCnt++;
              seen = txLine;
            end
            @(negedge clk);
          end
          check(errCnt == 0, s.tag, seen, s.lvl);
          fin = s.last || (expQ.size() == 0);
        end
        check(txLine === 1'b1, "R1 idle after frame", txLine, 1);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int   k;
    int   errCnt;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txLine === 1'b1 && inReady === 1'b1 && busy === 1'b0, "R1 reset",
          {txLine, inReady, busy}, 3'b110);

    // Framing across lengths, parities and stop lengths (R3..R7)
    sendFrame(8'hA5, 2'd3, 1'b0, 1'b0, 2'd0, 1);
    sendFrame(8'hE6, 2'd0, 1'b1, 1'b0, 2'd1, 1);
    sendFrame(8'h5A, 2'd1, 1'b1, 1'b1, 2'd2, 1);
    sendFrame(8'h81, 2'd2, 1'b1, 1'b0, 2'd3, 1);
    sendFrame(8'hFF, 2'd3, 1'b1, 1'b1, 2'd1, 1);
    sendFrame(8'h00, 2'd3, 1'b1, 1'b0, 2'd0, 1);
    sendFrame(8'hE0, 2'd0, 1'b1, 1'b1, 2'd1, 1);
    waitDrain();
    check(expQ.size() == 0, "R6 all frames seen", expQ.size(), 0);

    // R8: no progress without tick enable
    tickEn = 1'b0;
    sendFrame(8'h96, 2'd3, 1'b0, 1'b0, 2'd0, 0);
    errCnt = 0;
    for (int i = 0; i < 100; i++) begin
      if (txLine !== 1'b0 || busy !== 1'b1) errCnt++;
      @(negedge clk);
    end
    check(errCnt == 0, "R8 stalled line", errCnt, 0);
    tickEn = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (busy && k < 1000);
    check(k == 160, "R8 frame length in ticks", k, 160);
    repeat (3) @(negedge clk);

    // R9/R10: break in the middle of a frame
    sendFrame(8'hFF, 2'd3, 1'b0, 1'b0, 2'd0, 0);
    repeat (40) @(negedge clk);
    check(txLine === 1'b1, "R3 data high before break", txLine, 1);
    breakReq = 1'b1;
    @(negedge clk);
    check(txLine === 1'b0 && inReady === 1'b0, "R9 break entry",
          {txLine, inReady}, 2'b00);
    errCnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txLine !== 1'b0 || inReady !== 1'b0) errCnt++;
    end
    check(errCnt == 0, "R9 break held low", errCnt, 0);
    breakReq = 1'b0;
    errCnt = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (txLine !== 1'b1 || busy !== 1'b1 || inReady !== 1'b0) errCnt++;
    end
    check(errCnt == 0, "R10 recovery window", errCnt, 0);
    @(negedge clk);
    check(busy === 1'b0 && inReady === 1'b1, "R10 idle after recovery",
          {busy, inReady}, 2'b01);
    errCnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (txLine !== 1'b1 || busy !== 1'b0) errCnt++;
    end
    check(errCnt == 0, "R9 frame abandoned", errCnt, 0);

    // R9: break from idle
    breakReq = 1'b1;
    @(negedge clk);
    check(txLine === 1'b0 && inReady === 1'b0 && busy === 1'b1, "R9 idle break",
          {txLine, inReady, busy}, 3'b001);
    breakReq = 1'b0;
    repeat (20) @(negedge clk);
    check(txLine === 1'b1 && busy === 1'b0, "R10 idle break released",
          {txLine, busy}, 2'b10);

    // Clean framing after a break
    sendFrame(8'h6B, 2'd2, 1'b1, 1'b1, 2'd2, 1);
    waitDrain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule